// File: doc/BRIEF.md
# Burst ROM Read Sequencer

This block drives the external bus for one memory area that holds ROM with nibble (burst) access. A read request brings a start address, the ROM port width, a burst-length code and a programmed wait-state count. The block asserts chip select and read strobe, presents the address, and returns one data word per beat with a one-cycle valid strobe. In a burst, chip select and read strobe stay low from the first beat to the last, and only the address advances by the port width between beats.

The first beat uses the programmed wait count, as a normal single access would. Every later beat gets at least two wait cycles, even when zero are programmed. The external WAIT input can stretch a beat one cycle at a time. On the first beat it is sampled only when at least one wait state is programmed. On later beats it is always sampled. A transfer-type input marks accesses for which WAIT must be ignored entirely. Examples are write-back traffic or 16-byte DMA moves.

A burst-length code of zero gives a plain single access. A code that the chosen width does not allow is reduced to the largest length that the width does allow.

Top module: `burst_rom_seq`

## Requirements
- R1: With `req_blen` = 0 the request makes exactly one beat. Its `beat_last` is 1, and chip select rises in the cycle where that beat's valid is high.
- R2: `req_width` selects the port width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. `req_blen` codes 1, 2 and 3 give bursts of 4, 8 and 16 beats.
- R3: A length the width does not allow is clamped to the largest legal one. A 16-bit port allows at most 8 beats. A 32-bit port allows only 4 beats (codes 1 to 3 all give 4).
- R4: Beat k reads address `req_addr` + k·(1, 2 or 4 bytes per width). Its `beat_data` equals `rom_data` at that address. `rom_cs_n` and `rom_rd_n` stay low from acceptance until the final beat.
- R5: With WAIT not stretching it, the first beat's `beat_valid` is high in the cycle that starts W+1 clock edges after the accepting edge, where W is `req_waits`.
- R6: With WAIT not stretching them, later beats follow each other every max(W,2)+1 cycles, and `beat_valid` is a single-cycle pulse.
- R7: On the first beat, WAIT is sampled only when W ≥ 1. Each sampled high WAIT delays that beat by one cycle. With W = 0, WAIT has no effect on the first beat.
- R8: On the second and later beats, WAIT is always sampled. Each sampled high WAIT delays that beat by one cycle.
- R9: When `req_nowait` is 1 at acceptance, WAIT is ignored for the whole transfer.
- R10: `busy` is high from acceptance through the cycle of the final `beat_valid` and low in the cycle after it. Only the final beat carries `beat_last` = 1.
- R11: A request presented while `busy` is high is ignored and does not change the transfer in progress.
- R12: After reset, `busy` and `beat_valid` are 0 and `rom_cs_n` and `rom_rd_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request, taken when not busy |
| req_addr | input | ADDR_W | Start byte address |
| req_width | input | 2 | Port width code |
| req_blen | input | 2 | Burst-length code |
| req_waits | input | WAIT_W | Programmed wait cycles |
| req_nowait | input | 1 | Ignore WAIT for this transfer |
| busy | output | 1 | Transfer in progress |
| rom_cs_n | output | 1 | Chip select, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_addr | output | ADDR_W | ROM address |
| rom_wait | input | 1 | External WAIT, high stretches a beat |
| rom_data | input | DATA_W | ROM read data |
| beat_valid | output | 1 | One-cycle data strobe |
| beat_data | output | DATA_W | Captured beat data |
| beat_last | output | 1 | Marks the final beat |

## Verification
Every result is timed from the edge that accepts the request. Beat k is due in the cycle after edge W+1+k·(max(W,2)+1), and each sampled high WAIT moves it later by one cycle. Chip select and busy follow from that same edge count. The bench drives inputs and samples outputs at falling edges, numbering each falling edge by how many rising edges have passed since acceptance. It compares each beat's arrival number, data and last flag against the value worked out from these formulas. WAIT is released at a chosen count, so the exact number of stretched cycles is known in advance.

// File: rtl/burst_rom_seq.sv
module burst_rom_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_width,
  input  logic [1:0]        req_blen,
  input  logic [WAIT_W-1:0] req_waits,
  input  logic              req_nowait,
  output logic              busy,
  output logic              rom_cs_n,
  output logic              rom_rd_n,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic              rom_wait,
  input  logic [DATA_W-1:0] rom_data,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic              beat_last
);

  localparam logic [WAIT_W-1:0] MIN_LATER = WAIT_W'(2);
  localparam logic [CNT_W-1:0]  ONE_BEAT  = CNT_W'(1);

  logic              active, first_q, nowait_q, dv_q, last_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        step_q;
  logic [WAIT_W-1:0] wcfg_q, cnt_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;

  logic [1:0]        blen_eff;
  logic [CNT_W-1:0]  beats;
  logic [2:0]        step;
  logic [WAIT_W-1:0] later_w;
  logic              accept, sample_en, stall, done_beat;

  always_comb begin
    case (req_width)
      2'd0:    blen_eff = req_blen;
      2'd1:    blen_eff = (req_blen == 2'd3) ? 2'd2 : req_blen;
      default: blen_eff = (req_blen != 2'd0) ? 2'd1 : 2'd0;
    endcase
  end

  assign beats   = (blen_eff == 2'd0) ? ONE_BEAT : (CNT_W'(2) << blen_eff);
  assign step    = (req_width == 2'd0) ? 3'd1 : (req_width == 2'd1) ? 3'd2 : 3'd4;
  assign later_w = (wcfg_q < MIN_LATER) ? MIN_LATER : wcfg_q;

  assign busy      = active | (dv_q & last_q);
  assign accept    = req_valid & ~busy;
  assign sample_en = ~nowait_q & (~first_q | (wcfg_q != '0));
  assign stall     = sample_en & rom_wait;
  assign done_beat = active & (cnt_q == '0) & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      first_q  <= 1'b0;
      nowait_q <= 1'b0;
      dv_q     <= 1'b0;
      last_q   <= 1'b0;
      addr_q   <= '0;
      step_q   <= 3'd1;
      wcfg_q   <= '0;
      cnt_q    <= '0;
      left_q   <= '0;
      data_q   <= '0;
    end else begin
      dv_q   <= done_beat;
      last_q <= done_beat & (left_q == ONE_BEAT);
      if (done_beat) data_q <= rom_data;
      if (accept) begin
        active   <= 1'b1;
        first_q  <= 1'b1;
        nowait_q <= req_nowait;
        addr_q   <= req_addr;
        step_q   <= step;
        wcfg_q   <= req_waits;
        cnt_q    <= req_waits;
        left_q   <= beats;
      end else if (active) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (done_beat) begin
          if (left_q == ONE_BEAT) begin
            active <= 1'b0;
          end else begin
            addr_q  <= addr_q + ADDR_W'(step_q);
            cnt_q   <= later_w;
            first_q <= 1'b0;
            left_q  <= left_q - 1'b1;
          end
        end
      end
    end
  end

  assign rom_cs_n   = ~active;
  assign rom_rd_n   = ~active;
  assign rom_addr   = addr_q;
  assign beat_valid = dv_q;
  assign beat_data  = data_q;
  assign beat_last  = dv_q & last_q;

endmodule

// File: rtl/burst_rom_chk.sv
module burst_rom_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rom_cs_n,
  input logic              rom_rd_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              beat_valid,
  input logic              beat_last
);

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> busy); // R10

  AST_LAST_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last) |-> (rom_cs_n && rom_rd_n)); // R10

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last) |=> !busy); // R10

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> !beat_valid); // R6

  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_cs_n) |-> (beat_valid && beat_last)); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && $past(!rom_cs_n) && !beat_valid) |-> $stable(rom_addr)); // R4

endmodule

bind burst_rom_seq burst_rom_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rom_cs_n(rom_cs_n),
  .rom_rd_n(rom_rd_n), .rom_addr(rom_addr), .beat_valid(beat_valid),
  .beat_last(beat_last)
);

// File: tb/burst_rom_seq_tb.sv
module burst_rom_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_width = '0;
  logic [1:0]  req_blen = '0;
  logic [3:0]  req_waits = '0;
  logic        req_nowait = 1'b0;
  logic        busy, rom_cs_n, rom_rd_n, beat_valid, beat_last;
  logic [31:0] rom_addr, beat_data, rom_data;
  logic        rom_wait = 1'b0;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] romf(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, a[15:0]};
  endfunction
  assign rom_data = romf(rom_addr);

  burst_rom_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_width(req_width), .req_blen(req_blen), .req_waits(req_waits),
    .req_nowait(req_nowait), .busy(busy), .rom_cs_n(rom_cs_n),
    .rom_rd_n(rom_rd_n), .rom_addr(rom_addr), .rom_wait(rom_wait),
    .rom_data(rom_data), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_last(beat_last)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // one burst: expected beat k at edge t0 + k*g (+e once k >= sidx)
  task automatic run_burst(input string rq, input logic [31:0] addr, input logic [1:0] w,
                           input logic [1:0] bl, input logic [3:0] ws, input bit nw,
                           input int hold, input int n, input int t0, input int g,
                           input int sidx, input int e, input bit inject);
    int acc, rel, k, stepb, viol, t;
    bit fin;
    stepb = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_width = w; req_blen = bl;
    req_waits = ws; req_nowait = nw; rom_wait = (hold > 0);
    acc = cyc + 1;
    k = 0; viol = 0; fin = 1'b0;
    for (int i = 0; i < 400 && !fin; i++) begin
      @(negedge clk);
      rel = cyc - acc;
      req_valid = 1'b0;
      if (inject && rel == 2) begin
        req_valid = 1'b1; req_addr = addr ^ 32'h0000_F0F0; req_blen = 2'd0;
      end
      rom_wait = (rel < hold);
      if (beat_valid) begin
        t = t0 + k * g + ((k >= sidx) ? e : 0);
        chk(rel == t, {rq, " R5 R6 R7 R8 timing"}, rel, t);
        chk(beat_data == romf(addr + 32'(k * stepb)), {rq, " R4 data"},
            beat_data, romf(addr + 32'(k * stepb)));
        chk(beat_last == (k == n - 1), {rq, " R10 last flag"}, beat_last, (k == n - 1));
        if (k == n - 1) begin
          chk(rom_cs_n && rom_rd_n && busy, {rq, " R1 R10 release"},
              {rom_cs_n, rom_rd_n, busy}, 3'b111);
          fin = 1'b1;
        end
        k++;
      end else if (rom_cs_n || rom_rd_n) viol++;
    end
    chk(fin && k == n, {rq, " R2 R3 beat count"}, k, n);
    chk(viol == 0, {rq, " R4 cs held"}, viol, 0);
    @(negedge clk);
    req_valid = 1'b0; rom_wait = 1'b0;
    chk(!busy && rom_cs_n && !beat_valid, {rq, " R10 R11 idle after"}, {busy, rom_cs_n}, 2'b01);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!busy && rom_cs_n && rom_rd_n && !beat_valid, "R12 reset state",
        {busy, rom_cs_n, rom_rd_n, beat_valid}, 4'b0110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && rom_cs_n, "R12 idle after reset", {busy, rom_cs_n}, 2'b01);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_burst("R1 single 8b W2",      32'h0000_1000, 2'd0, 2'd0, 4'd2, 1'b0, 0,   1,  3, 3, 99, 0, 1'b0);
        run_burst("R2 8b x16 W0 +R11",    32'h0000_2003, 2'd0, 2'd3, 4'd0, 1'b0, 0,   16, 1, 3, 99, 0, 1'b1);
        run_burst("R6 16b x8 W3",         32'h0000_3000, 2'd1, 2'd2, 4'd3, 1'b0, 0,   8,  4, 4, 99, 0, 1'b0);
        run_burst("R3 16b code16",        32'h0000_4000, 2'd1, 2'd3, 4'd0, 1'b0, 0,   8,  1, 3, 99, 0, 1'b0);
        run_burst("R3 32b code8",         32'h0000_5000, 2'd2, 2'd2, 4'd0, 1'b0, 0,   4,  1, 3, 99, 0, 1'b0);
        run_burst("R2 32b code3 x4",      32'h0000_5800, 2'd3, 2'd1, 4'd1, 1'b0, 0,   4,  2, 3, 99, 0, 1'b0);
        run_burst("R8 stall later beat",  32'h0000_6000, 2'd2, 2'd1, 4'd0, 1'b0, 5,   4,  1, 3, 1,  2, 1'b0);
        run_burst("R9 nowait",            32'h0000_7000, 2'd2, 2'd1, 4'd0, 1'b1, 200, 4,  1, 3, 99, 0, 1'b0);
        run_burst("R7 first W1 stall",    32'h0000_8000, 2'd0, 2'd0, 4'd1, 1'b0, 3,   1,  4, 3, 99, 0, 1'b0);
        run_burst("R7 first W0 ignore",   32'h0000_9000, 2'd0, 2'd0, 4'd0, 1'b0, 10,  1,  1, 3, 99, 0, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule